// File: doc/BRIEF.md
# Two-Class Programmable Interrupt Controller

The block gathers up to `N_SRC` interrupt request lines from peripherals and turns them into two processor interrupt outputs, one normal (`irq_o`) and one fast (`fiq_o`). For each line, software picks the asserted level, whether the line is treated as a level or as an edge, whether it is enabled, and which of the two outputs it drives. Edge events are held in a per-line latch until software clears them with a write-one-to-clear register.

Software reaches the controller through a single-cycle register port with separate read and write addresses. Reads are combinational. The register set covers the configuration fields and the status views: synchronized raw lines, pending lines, enabled pending lines, and enabled pending lines split by class. For each class there is also a binary index of the lowest-numbered pending line. An interrupt handler can read this index directly instead of scanning a bit vector.

Top module: `dual_class_intc`

## Requirements
- R1: After reset, enable (word 0), trigger (word 2) and class (word 3) read 0, polarity (word 1) reads all ones, both outputs are low, and both index words (10, 11) read 32'h8000_0000.
- R2: Each input passes through two flops before it reaches any logic. A level change made between clock edges shows up in the raw word (word 5, bit n = line n) after the second rising edge, and not after the first.
- R3: Polarity bit n set to 1 makes line n active high. Set to 0, it makes line n active low, so a low line counts as asserted.
- R4: Trigger bit n set to 0 selects level mode. In level mode, the pending word (word 6) bit n follows the polarity-adjusted synchronized line and drops when the line is released.
- R5: Trigger bit n set to 1 selects edge mode. An inactive-to-active transition of the synchronized line sets a latch. The latch keeps pending bit n set after the line goes inactive again.
- R6: Writing word 4 clears every edge latch whose data bit is 1. Bits written as 0 leave their latches unchanged. Word 4 reads 0.
- R7: If a new edge and a clear for the same line land on the same clock edge, the latch stays set.
- R8: The masked word (word 7) equals pending AND enable (word 0, 1 = enabled).
- R9: Class bit n set to 0 routes line n to the normal class, and set to 1 routes it to the fast class. Word 8 shows the enabled pending normal lines and word 9 the fast lines. `irq_o` is high exactly when word 8 is nonzero, and `fiq_o` exactly when word 9 is nonzero.
- R10: Word 10 (normal) and word 11 (fast) give the number of the lowest-numbered pending line of that class. When that class has no pending line, they read 32'h8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write word address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read word address |
| rd_data_o | output | DW | Read data, combinational |
| irq_o | output | 1 | Normal-class interrupt |
| fiq_o | output | 1 | Fast-class interrupt |

## Verification
The collision that matters is between a software clear of an edge latch and a fresh edge on the same line in the same cycle. The bench first latches a line and lets it fall. It then raises the line again and times the write to the clear word so that the write lands on the very edge at which the synchronized line becomes active. It judges the result by reading the pending word: the bit must still be set. A second clear with no competing edge must then empty the latch.

// File: rtl/dual_class_intc.sv
module dual_class_intc #(
  parameter int N_SRC = 32,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam int IW = $clog2(N_SRC);
  localparam logic [DW-1:0] NONE = DW'(1) << (DW-1);

  localparam logic [AW-1:0] A_EN   = AW'(0);
  localparam logic [AW-1:0] A_POL  = AW'(1);
  localparam logic [AW-1:0] A_TRG  = AW'(2);
  localparam logic [AW-1:0] A_CLS  = AW'(3);
  localparam logic [AW-1:0] A_CLR  = AW'(4);
  localparam logic [AW-1:0] A_RAW  = AW'(5);
  localparam logic [AW-1:0] A_PND  = AW'(6);
  localparam logic [AW-1:0] A_MSK  = AW'(7);
  localparam logic [AW-1:0] A_NST  = AW'(8);
  localparam logic [AW-1:0] A_FST  = AW'(9);
  localparam logic [AW-1:0] A_NID  = AW'(10);
  localparam logic [AW-1:0] A_FID  = AW'(11);

  logic [N_SRC-1:0] meta_q, sync_q, act_q, edge_q;
  logic [N_SRC-1:0] en_q, pol_q, trg_q, cls_q;
  logic [N_SRC-1:0] act, rise, clr, pend, masked, nrm_st, fst_st;
  logic [DW-1:0]    nrm_id, fst_id;

  function automatic logic [DW-1:0] lowest(input logic [N_SRC-1:0] v);
    logic [DW-1:0] r;
    r = NONE;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (v[i]) r = DW'(i);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
    end

  assign act  = sync_q ~^ pol_q;
  assign rise = act & ~act_q;
  assign clr  = (wr_en_i && wr_addr_i == A_CLR) ? wr_data_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q  <= '0;
      edge_q <= '0;
    end else begin
      act_q  <= act;
      edge_q <= (edge_q & ~clr) | rise;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '1;
      trg_q <= '0;
      cls_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_EN:    en_q  <= wr_data_i[N_SRC-1:0];
        A_POL:   pol_q <= wr_data_i[N_SRC-1:0];
        A_TRG:   trg_q <= wr_data_i[N_SRC-1:0];
        A_CLS:   cls_q <= wr_data_i[N_SRC-1:0];
        default: ;
      endcase
    end

  assign pend   = (trg_q & edge_q) | (~trg_q & act);
  assign masked = pend & en_q;
  assign nrm_st = masked & ~cls_q;
  assign fst_st = masked & cls_q;
  assign nrm_id = lowest(nrm_st);
  assign fst_id = lowest(fst_st);
  assign irq_o  = |nrm_st;
  assign fiq_o  = |fst_st;

  always_comb begin
    case (rd_addr_i)
      A_EN:    rd_data_o = DW'(en_q);
      A_POL:   rd_data_o = DW'(pol_q);
      A_TRG:   rd_data_o = DW'(trg_q);
      A_CLS:   rd_data_o = DW'(cls_q);
      A_RAW:   rd_data_o = DW'(sync_q);
      A_PND:   rd_data_o = DW'(pend);
      A_MSK:   rd_data_o = DW'(masked);
      A_NST:   rd_data_o = DW'(nrm_st);
      A_FST:   rd_data_o = DW'(fst_st);
      A_NID:   rd_data_o = nrm_id;
      A_FID:   rd_data_o = fst_id;
      default: rd_data_o = '0;
    endcase
  end

  // R5
  latch_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(rise)) == '0));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_CLR) |=> ((edge_q & $past(wr_data_i[N_SRC-1:0] & ~rise)) == '0));

  // R10
  nrm_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nrm_id[DW-1] |-> (nrm_st[nrm_id[IW-1:0]] &&
      ((nrm_st & ((N_SRC'(1) << nrm_id[IW-1:0]) - N_SRC'(1))) == '0)));

  // R10
  fst_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fst_id[DW-1] |-> (fst_st[fst_id[IW-1:0]] &&
      ((fst_st & ((N_SRC'(1) << fst_id[IW-1:0]) - N_SRC'(1))) == '0)));

  // R9
  empty_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm_id[DW-1] && fst_id[DW-1]) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/dual_class_intc_tb.sv
module dual_class_intc_tb_top;
  localparam int N = 32;
  localparam logic [3:0] OUTS = 4'hF;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq, fiq;

  dual_class_intc dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .fiq_o(fiq));

  always #10 clk = ~clk;

  typedef struct { string req; logic [3:0] addr; logic [31:0] exp; } item_t;
  item_t q[$];
  int outstanding = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  initial forever begin
    wait (q.size() > 0);
    begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      rd_addr = it.addr;
      #1;
      got = (it.addr == OUTS) ? {30'b0, fiq, irq} : rd_data;
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s word %0d: got %h expected %h", it.req, it.addr, got, it.exp);
      end
      outstanding--;
    end
  end

  task automatic chk(input string req, input logic [3:0] a, input logic [31:0] e);
    item_t it;
    it.req = req; it.addr = a; it.exp = e;
    outstanding++;
    q.push_back(it);
    wait (outstanding == 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1;
    chk("R1", 0, 32'h0);
    chk("R1", OUTS, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 1, 32'hFFFF_FFFF);
    chk("R1", 2, 32'h0);
    chk("R1", 3, 32'h0);
    chk("R1", 10, 32'h8000_0000);
    chk("R1", 11, 32'h8000_0000);

    src[3] = 1;
    clocks(1);
    chk("R2", 5, 32'h0);
    clocks(1);
    chk("R2", 5, 32'h8);

    wr(0, 32'hFFFF_FFFF);
    chk("R4", 6, 32'h8);
    chk("R4", OUTS, 32'h1);
    chk("R10", 10, 32'd3);
    src[3] = 0;
    clocks(2);
    chk("R4", 6, 32'h0);
    chk("R10", 10, 32'h8000_0000);

    wr(1, 32'hFFFF_FFDF);
    clocks(2);
    chk("R3", 6, 32'h20);
    wr(1, 32'hFFFF_FFFF);
    chk("R3", 6, 32'h0);

    wr(2, 32'h80);
    src[7] = 1;
    clocks(1);
    src[7] = 0;
    clocks(4);
    chk("R5", 6, 32'h80);
    chk("R5", 5, 32'h0);

    wr(4, 32'hFFFF_FF7F);
    chk("R6", 6, 32'h80);
    chk("R6", 4, 32'h0);
    wr(4, 32'h80);
    chk("R6", 6, 32'h0);

    src[7] = 1;
    clocks(1);
    src[7] = 0;
    clocks(4);
    chk("R7", 6, 32'h80);
    src[7] = 1;
    clocks(2);
    wr(4, 32'h80);
    chk("R7", 6, 32'h80);
    clocks(1);
    wr(4, 32'h80);
    chk("R7", 6, 32'h0);
    src[7] = 0;
    wr(2, 32'h0);

    src[3] = 1; src[9] = 1;
    wr(0, 32'h8);
    clocks(2);
    chk("R8", 6, 32'h208);
    chk("R8", 7, 32'h8);

    wr(0, 32'h208);
    wr(3, 32'h200);
    chk("R9", 8, 32'h8);
    chk("R9", 9, 32'h200);
    chk("R9", OUTS, 32'h3);
    chk("R10", 10, 32'd3);
    chk("R10", 11, 32'd9);

    wr(0, 32'hFFFF_FFFF);
    src[1] = 1; src[31] = 1;
    clocks(2);
    chk("R10", 10, 32'd1);
    src[3] = 0; src[1] = 0; src[9] = 0;
    clocks(2);
    chk("R10", 10, 32'd31);
    chk("R10", 11, 32'h8000_0000);
    chk("R9", OUTS, 32'h1);
    src[31] = 0;
    clocks(2);
    chk("R10", 10, 32'h8000_0000);
    chk("R9", OUTS, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule